// File: doc/BRIEF.md
# I2C Master Bit Timing Engine

This block turns single bus-level commands into timed SCL and SDA waveforms for an I2C master. A controller above it presents one command at a time (START, repeated START, STOP, write one bit, read one bit) with a valid/ready handshake. The engine drives both lines as drive-low enables, watches the SCL input so that a slave holding the clock low lengthens the high phase, returns the sampled data bit for reads, and pulses `done` when the command has finished.

All intervals are counted in ticks of one shared time base whose period is set by a 4-bit prescaler. The SCL low and high counts set the clock shape and also set the bus-free, start-setup, start-hold and stop-setup times. A data-hold count and a data-setup count place the SDA edge inside the low phase. The 32-bit timing word is captured when a command is accepted, so software can rewrite it at any time without disturbing a command that is already running.

States: `ST_IDLE` (waiting; ready), `ST_LOW` (SCL held low, SDA updated after the hold count), `ST_SCL_WAIT` (SCL released, waiting for the line to read high), `ST_HIGH` (high phase of a data bit), `ST_STA_SETUP` (SDA high with SCL high before a START), `ST_STA_HOLD` (SDA low with SCL high before SCL falls), `ST_STO_SETUP` (SCL high with SDA low before SDA rises). Transitions: IDLE→STA_SETUP on an accepted START; IDLE→LOW on an accepted repeated START, STOP, write or read; IDLE→IDLE on an accepted unused code; LOW→SCL_WAIT when the low interval ends; SCL_WAIT→HIGH (bits), →STA_SETUP (repeated START) or →STO_SETUP (STOP) once SCL reads high; STA_SETUP→STA_HOLD, HIGH→IDLE, STA_HOLD→IDLE and STO_SETUP→IDLE when their intervals end.

Top module: `i2c_bit_engine`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both drive-low enables are 0, `cmd_ready` is 1, `done` is 0 and `rd_bit` is 0.
- R2: `cmd_ready` is 1 only in the idle state; a command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1, after which `cmd_ready` is 0 until it finishes (an unused code finishes at once). Codes: 0 START, 1 repeated START, 2 STOP, 3 write `cmd_wbit`, 4 read. The timing word is captured on acceptance; later changes to it have no effect on the running command.
- R3: Timing word fields: prescaler PRE in bits 31:28, low count LO in bits 7:0, high count HI in bits 15:8, hold count HD in bits 19:16, setup count SU in bits 23:20 (bits 27:24 ignored). One tick lasts PRE+1 clock cycles; the tick counter restarts when a command is accepted and when SCL is first seen high, so every interval is a whole number of ticks.
- R4: START (from a free bus): after LO+1 ticks SDA is pulled low; after HI+1 further ticks SCL is pulled low and `done` is raised.
- R5: For write, read, repeated START and STOP the command begins with SCL low; SDA takes its new level HD ticks after acceptance (HD=0: on the acceptance edge) and SCL is released after max(LO+1, HD+SU+1) ticks. Write 0 and STOP drive SDA low; write 1, read and repeated START release it.
- R6: After SCL is released, the next interval starts on the clock after `scl_in` reads 1; a slave holding SCL low delays every later line change by the same number of cycles.
- R7: For a data bit, SCL stays released for HI+1 ticks after it is seen high, then SCL is pulled low and `done` is raised on the same edge; SDA does not change while SCL is released.
- R8: For a read, `rd_bit` takes the value of `sda_in` on the edge where the high interval ends.
- R9: Repeated START: after SCL is seen high, LO+1 ticks pass, SDA is pulled low, HI+1 ticks pass, then SCL is pulled low together with `done`.
- R10: STOP: after SCL is seen high, HI+1 ticks pass, then SDA is released together with `done`; SCL stays released.
- R11: An unused code (5, 6 or 7) is accepted, raises `done` on the acceptance edge and leaves both lines unchanged.
- R12: `done` is high for exactly one cycle, in the cycle where the command's last line change is visible; `rd_bit` changes only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timing_word | input | 32 | Prescaler, low/high counts, hold and setup counts |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_code | input | 3 | Command code (0..4, others unused) |
| cmd_wbit | input | 1 | Data bit for a write command |
| done | output | 1 | One-cycle completion pulse |
| rd_bit | output | 1 | Bit sampled by the last read |
| scl_in | input | 1 | Sensed level of the SCL line |
| sda_in | input | 1 | Sensed level of the SDA line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions assume a legal command order: a START only on a free bus (both lines released), and bit, repeated START and STOP commands only while the engine is holding SCL low after a previous command; under that rule SCL is already low on entry to the low state and SDA stays frozen during the high phase. They also assume `scl_in` reads high eventually once SCL is released. The stimulus always opens with START, ends with STOP, keeps the slave's SDA pull released during writes, and models clock stretching as a bounded number of cycles after each release.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;

    localparam int TW_W    = 32;
    localparam int LO_W    = 8;
    localparam int HI_W    = 8;
    localparam int HD_W    = 4;
    localparam int SU_W    = 4;
    localparam int PRE_W   = 4;
    localparam int RSV_W   = TW_W - LO_W - HI_W - HD_W - SU_W - PRE_W;
    localparam int CNT_W   = LO_W + 2;
    localparam int CMD_W   = 3;

    localparam logic [CMD_W-1:0] CMD_START   = 3'd0;
    localparam logic [CMD_W-1:0] CMD_RESTART = 3'd1;
    localparam logic [CMD_W-1:0] CMD_STOP    = 3'd2;
    localparam logic [CMD_W-1:0] CMD_WRITE   = 3'd3;
    localparam logic [CMD_W-1:0] CMD_READ    = 3'd4;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [RSV_W-1:0] rsv;
        logic [SU_W-1:0]  setup;
        logic [HD_W-1:0]  hold;
        logic [HI_W-1:0]  high;
        logic [LO_W-1:0]  low;
    } timing_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_SCL_WAIT,
        ST_HIGH,
        ST_STA_SETUP,
        ST_STA_HOLD,
        ST_STO_SETUP
    } state_e;

endpackage

// File: rtl/i2c_bt_tick.sv
module i2c_bt_tick #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] div_q;

    assign tick = (div_q == limit) && !clear;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clear || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + W'(1);
        end
    end
endmodule

// File: rtl/i2c_bt_ivl.sv
module i2c_bt_ivl #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    input  logic [W-1:0] target,
    output logic [W-1:0] count,
    output logic         expire
);
    assign expire = tick && ((count + W'(1)) == target);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (tick) begin
            count <= count + W'(1);
        end
    end
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
    import i2c_bt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TW_W-1:0]   timing_word,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [CMD_W-1:0]  cmd_code,
    input  logic              cmd_wbit,
    output logic              done,
    output logic              rd_bit,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low
);
    state_e             state_q, state_d;
    timing_t            tw_q;
    timing_t            tw_in;
    logic [CMD_W-1:0]   cmd_q;
    logic               rel_q;

    logic               accept, tick, clr_pre, clr_ivl, expire, data_go, high_seen;
    logic               rel_in, low_cmd_in, unused_in;
    logic [CNT_W-1:0]   ivl_count, ivl_target;
    logic [CNT_W-1:0]   t_low, t_high, t_hold, t_data, t_need;

    assign tw_in      = timing_t'(timing_word);
    assign cmd_ready  = (state_q == ST_IDLE);
    assign accept     = cmd_valid && cmd_ready;
    assign high_seen  = (state_q == ST_SCL_WAIT) && scl_in;

    assign low_cmd_in = (cmd_code == CMD_RESTART) || (cmd_code == CMD_STOP) ||
                        (cmd_code == CMD_WRITE)   || (cmd_code == CMD_READ);
    assign unused_in  = !low_cmd_in && (cmd_code != CMD_START);
    assign rel_in     = (cmd_code == CMD_RESTART) || (cmd_code == CMD_READ) ||
                        ((cmd_code == CMD_WRITE) && cmd_wbit);

    // interval lengths in ticks, from the captured word
    assign t_low  = CNT_W'(tw_q.low)  + CNT_W'(1);
    assign t_high = CNT_W'(tw_q.high) + CNT_W'(1);
    assign t_hold = CNT_W'(tw_q.hold);
    assign t_data = t_hold + CNT_W'(tw_q.setup) + CNT_W'(1);
    assign t_need = (t_low > t_data) ? t_low : t_data;

    always_comb begin
        unique case (state_q)
            ST_LOW:       ivl_target = t_need;
            ST_HIGH:      ivl_target = t_high;
            ST_STA_SETUP: ivl_target = t_low;
            ST_STA_HOLD:  ivl_target = t_high;
            ST_STO_SETUP: ivl_target = t_high;
            default:      ivl_target = '0;
        endcase
    end

    assign clr_pre = accept || high_seen;
    assign clr_ivl = (state_q == ST_IDLE) || (state_q != state_d);
    assign data_go = (state_q == ST_LOW) && tick &&
                     ((ivl_count + CNT_W'(1)) == t_hold);

    i2c_bt_tick #(.W(PRE_W)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clr_pre),
        .limit (tw_q.pre),
        .tick  (tick)
    );

    i2c_bt_ivl #(.W(CNT_W)) ivl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clr_ivl),
        .tick   (tick),
        .target (ivl_target),
        .count  (ivl_count),
        .expire (expire)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (cmd_code == CMD_START) state_d = ST_STA_SETUP;
                    else if (low_cmd_in)       state_d = ST_LOW;
                end
            end
            ST_LOW:       if (expire) state_d = ST_SCL_WAIT;
            ST_SCL_WAIT: begin
                if (scl_in) begin
                    if (cmd_q == CMD_STOP)         state_d = ST_STO_SETUP;
                    else if (cmd_q == CMD_RESTART) state_d = ST_STA_SETUP;
                    else                           state_d = ST_HIGH;
                end
            end
            ST_HIGH:      if (expire) state_d = ST_IDLE;
            ST_STA_SETUP: if (expire) state_d = ST_STA_HOLD;
            ST_STA_HOLD:  if (expire) state_d = ST_IDLE;
            ST_STO_SETUP: if (expire) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and command capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tw_q          <= '0;
            cmd_q         <= '0;
            rel_q         <= 1'b0;
            scl_drive_low <= 1'b0;
            sda_drive_low <= 1'b0;
            done          <= 1'b0;
            rd_bit        <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        tw_q  <= tw_in;
                        cmd_q <= cmd_code;
                        rel_q <= rel_in;
                        if (low_cmd_in && (tw_in.hold == '0)) sda_drive_low <= !rel_in;
                        if (unused_in) done <= 1'b1;
                    end
                end
                ST_LOW: begin
                    if (data_go) sda_drive_low <= !rel_q;
                    if (expire)  scl_drive_low <= 1'b0;
                end
                ST_HIGH: begin
                    if (expire) begin
                        scl_drive_low <= 1'b1;
                        done          <= 1'b1;
                        if (cmd_q == CMD_READ) rd_bit <= sda_in;
                    end
                end
                ST_STA_SETUP: if (expire) sda_drive_low <= 1'b1;
                ST_STA_HOLD: begin
                    if (expire) begin
                        scl_drive_low <= 1'b1;
                        done          <= 1'b1;
                    end
                end
                ST_STO_SETUP: begin
                    if (expire) begin
                        sda_drive_low <= 1'b0;
                        done          <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_bt_chk.sv
module i2c_bt_chk
    import i2c_bt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             done,
    input logic             rd_bit,
    input logic             scl_drive_low,
    input logic             sda_drive_low,
    input state_e           state_q,
    input logic [CNT_W-1:0] ivl_count,
    input logic [CNT_W-1:0] ivl_target,
    input timing_t          tw_q
);
    // R2: a taken command makes the engine busy unless it finished at once
    p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (!cmd_ready || done));

    // R2: captured timing word is frozen while a command runs
    p_word_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_ready && $past(!cmd_ready)) |-> $stable(tw_q));

    // R3: the interval counter never passes its end inside a timed state
    p_count_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_LOW, ST_HIGH, ST_STA_SETUP, ST_STA_HOLD, ST_STO_SETUP})
        |-> (ivl_count < ivl_target));

    // R5: SCL is held low for the whole low phase
    p_scl_low_in_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOW) |-> scl_drive_low);

    // R7: SDA is frozen while SCL is released during a data bit
    p_sda_still_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH) |-> $stable(sda_drive_low));

    // R12: completion only ever seen while idle
    p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready);

    // R12: read result moves only with a completion pulse
    p_rd_with_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_bit) |-> done);
endmodule

bind i2c_bit_engine i2c_bt_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .done          (done),
    .rd_bit        (rd_bit),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .state_q       (state_q),
    .ivl_count     (ivl_count),
    .ivl_target    (ivl_target),
    .tw_q          (tw_q)
);

// File: tb/i2c_bit_engine_tb_top.sv
module i2c_bit_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] timing_word = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_code = '0;
    logic        cmd_wbit = 1'b0;
    logic        done, rd_bit;
    logic        scl_in, sda_in;
    logic        scl_drive_low, sda_drive_low;

    int  cyc = 0;
    int  n_chk = 0;
    int  n_bad = 0;
    int  kstretch = 0;
    int  rel_cnt = 0;
    bit  slave_low = 1'b0;
    bit  finished = 1'b0;
    bit  m_scl = 1'b0, m_sda = 1'b0;
    logic p_scl = 1'b0, p_sda = 1'b0, p_done = 1'b0;

    typedef struct {
        int    sig;   // 0 sda, 1 scl, 2 done
        bit    val;
        int    at;
        bit    crd;
        bit    rd;
        string tag;
    } ev_t;
    ev_t evq[$];

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (scl_drive_low) rel_cnt <= 0;
        else if (rel_cnt < 1000) rel_cnt <= rel_cnt + 1;
    end

    assign scl_in = !scl_drive_low && (rel_cnt >= kstretch);
    assign sda_in = !sda_drive_low && !slave_low;

    i2c_bit_engine dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .timing_word   (timing_word),
        .cmd_valid     (cmd_valid),
        .cmd_ready     (cmd_ready),
        .cmd_code      (cmd_code),
        .cmd_wbit      (cmd_wbit),
        .done          (done),
        .rd_bit        (rd_bit),
        .scl_in        (scl_in),
        .sda_in        (sda_in),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic push(input int sig, input bit val, input int at,
                        input bit crd, input bit rd, input string tag);
        ev_t e;
        e.sig = sig; e.val = val; e.at = at; e.crd = crd; e.rd = rd; e.tag = tag;
        evq.push_back(e);
    endtask

    task automatic got(input int sig, input bit val);
        ev_t e;
        if (evq.size() == 0) begin
            check(1'b0, $sformatf("unexpected change sig%0d", sig), int'(val), -1);
        end else begin
            e = evq.pop_front();
            check(e.sig == sig && e.val == val && e.at == cyc,
                  $sformatf("%s sig%0d val%0d at", e.tag, e.sig, e.val), cyc, e.at);
            if (e.crd) check(rd_bit == e.rd, {e.tag, " R8 read bit"}, int'(rd_bit), int'(e.rd));
        end
    endtask

    // monitor: compares every observed line change and done pulse with the queue
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (sda_drive_low !== p_sda) got(0, sda_drive_low);
            if (scl_drive_low !== p_scl) got(1, scl_drive_low);
            if (done && !p_done) got(2, 1'b1);
            if (done && p_done) check(1'b0, "R12 done wider than one cycle", 2, 1);
            p_sda  = sda_drive_low;
            p_scl  = scl_drive_low;
            p_done = done;
        end
    end

    function automatic logic [31:0] mk(input int pre, input int lo, input int hi,
                                       input int hd, input int su);
        return {pre[3:0], 4'h0, su[3:0], hd[3:0], hi[7:0], lo[7:0]};
    endfunction

    // driver: issues one command and queues its expected line events
    task automatic issue(input logic [2:0] code, input bit wb, input logic [31:0] tw,
                         input int k, input bit sl, input bit chg, input string note);
        int P, L, H, h, s, need, A, R, hs, last;
        bit tgt;
        bit legal;
        P = int'(tw[31:28]) + 1;
        L = int'(tw[7:0]) + 1;
        H = int'(tw[15:8]) + 1;
        h = int'(tw[19:16]);
        s = int'(tw[23:20]);
        need = (L > h + s + 1) ? L : h + s + 1;
        kstretch  = k;
        slave_low = sl;
        legal = (code <= 3'd4);
        @(negedge clk);
        timing_word = tw;
        cmd_code    = code;
        cmd_wbit    = wb;
        cmd_valid   = 1'b1;
        A = cyc + 1;
        last = A;
        if (code == 3'd0) begin
            push(0, 1'b1, A + L*P, 0, 0, {"R4 ", note});
            last = A + (L + H)*P;
            push(1, 1'b1, last, 0, 0, {"R4 ", note});
            push(2, 1'b1, last, 0, 0, {"R4 ", note});
            m_sda = 1'b1; m_scl = 1'b1;
        end else if (legal) begin
            if (code == 3'd3)      tgt = !wb;
            else if (code == 3'd2) tgt = 1'b1;
            else                   tgt = 1'b0;
            if (tgt != m_sda) push(0, tgt, A + h*P, 0, 0, {"R5 ", note});
            m_sda = tgt;
            R = A + need*P;
            push(1, 1'b0, R, 0, 0, {"R5 ", note});
            hs = R + 1 + k;
            if (code == 3'd1) begin
                push(0, 1'b1, hs + L*P, 0, 0, {"R9 R6 ", note});
                last = hs + (L + H)*P;
                push(1, 1'b1, last, 0, 0, {"R9 ", note});
                push(2, 1'b1, last, 0, 0, {"R9 ", note});
                m_sda = 1'b1; m_scl = 1'b1;
            end else if (code == 3'd2) begin
                last = hs + H*P;
                push(0, 1'b0, last, 0, 0, {"R10 R6 ", note});
                push(2, 1'b1, last, 0, 0, {"R10 ", note});
                m_sda = 1'b0; m_scl = 1'b0;
            end else begin
                last = hs + H*P;
                push(1, 1'b1, last, 0, 0, {"R7 R6 ", note});
                push(2, 1'b1, last, code == 3'd4, !sl, {"R7 ", note});
                m_scl = 1'b1;
            end
        end else begin
            push(2, 1'b1, A, 0, 0, {"R11 ", note});
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        if (legal) check(cmd_ready == 1'b0, {"R2 busy after take ", note}, int'(cmd_ready), 0);
        else       check(cmd_ready == 1'b1, {"R11 ready stays ", note}, int'(cmd_ready), 1);
        if (chg) timing_word = mk(15, 200, 200, 15, 15);
        while (cyc < last) @(negedge clk);
        @(negedge clk);
        check(done == 1'b0, {"R12 done cleared ", note}, int'(done), 0);
        check(scl_drive_low == m_scl, {legal ? "R2" : "R11", " scl level ", note},
              int'(scl_drive_low), int'(m_scl));
        check(sda_drive_low == m_sda, {legal ? "R2" : "R11", " sda level ", note},
              int'(sda_drive_low), int'(m_sda));
        check(cmd_ready == 1'b1, {"R2 ready when idle ", note}, int'(cmd_ready), 1);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", cyc, 100000);
        finish_up();
    end

    initial begin
        logic [31:0] tw1, tw2, tw3;
        tw1 = mk(0, 3, 2, 1, 1);
        tw2 = mk(2, 1, 1, 0, 5);
        tw3 = mk(1, 0, 0, 2, 0);
        repeat (3) @(negedge clk);
        check(scl_drive_low == 1'b0, "R1 scl in reset", int'(scl_drive_low), 0);
        check(cmd_ready == 1'b1, "R1 ready in reset", int'(cmd_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(scl_drive_low == 1'b0, "R1 scl after reset", int'(scl_drive_low), 0);
        check(sda_drive_low == 1'b0, "R1 sda after reset", int'(sda_drive_low), 0);
        check(cmd_ready == 1'b1, "R1 ready after reset", int'(cmd_ready), 1);
        check(done == 1'b0, "R1 done after reset", int'(done), 0);
        check(rd_bit == 1'b0, "R1 rd_bit after reset", int'(rd_bit), 0);

        // unit prescaler, low count dominates the low phase
        issue(3'd0, 1'b0, tw1, 0, 1'b0, 1'b0, "t1 start");
        issue(3'd3, 1'b0, tw1, 0, 1'b0, 1'b0, "t1 write0");
        issue(3'd3, 1'b1, tw1, 0, 1'b0, 1'b0, "t1 write1");
        issue(3'd4, 1'b0, tw1, 0, 1'b1, 1'b0, "t1 read0 R8");
        issue(3'd4, 1'b0, tw1, 0, 1'b0, 1'b0, "t1 read1 R8");
        issue(3'd2, 1'b0, tw1, 0, 1'b0, 1'b0, "t1 stop");

        // prescaler 3, zero hold, setup dominates the low phase
        issue(3'd0, 1'b0, tw2, 0, 1'b0, 1'b0, "t2 start R3");
        issue(3'd3, 1'b1, tw2, 0, 1'b0, 1'b0, "t2 write1 R3");
        issue(3'd3, 1'b0, tw2, 0, 1'b0, 1'b1, "t2 write0 word changed R2");
        issue(3'd1, 1'b0, tw2, 2, 1'b0, 1'b0, "t2 restart stretched R6");
        issue(3'd4, 1'b0, tw2, 3, 1'b1, 1'b0, "t2 read stretched R6 R8");
        issue(3'd2, 1'b0, tw2, 1, 1'b0, 1'b0, "t2 stop stretched R6");
        issue(3'd6, 1'b0, tw2, 0, 1'b0, 1'b0, "t2 unused on free bus R11");

        // prescaler 2, minimum low/high counts, hold dominates
        issue(3'd0, 1'b0, tw3, 0, 1'b0, 1'b0, "t3 start R3");
        issue(3'd7, 1'b0, tw3, 0, 1'b0, 1'b0, "t3 unused mid frame R11");
        issue(3'd3, 1'b1, tw3, 0, 1'b0, 1'b0, "t3 write1");
        issue(3'd4, 1'b0, tw3, 1, 1'b1, 1'b0, "t3 read0 R8");
        issue(3'd2, 1'b0, tw3, 0, 1'b0, 1'b0, "t3 stop");

        repeat (4) @(negedge clk);
        check(evq.size() == 0, "R12 all expected events seen", evq.size(), 0);
        finish_up();
    end
endmodule